// File: doc/BRIEF.md
# Display Controller Raw Interrupt Status

This unit collects four event sources of a display controller into sticky status flags: a bus master error, a vertical timing region match, a next-frame base address hand-over and a DMA FIFO underflow. Each flag is set by a rising edge of its condition. It stays set until software writes a one to its bit position in a 32-bit status word. The word sits at byte offset 0x20 of the unit's register window.

The vertical match condition is true while the current vertical timing phase equals a 2-bit region select. Each of the underflow and base-update conditions is the OR of an upper-panel input and a lower-panel input. While the bus error flag is set, a hold output tells the bus master to remain in its error state. A registered interrupt request is the OR of the four flags, each gated by its own bit of an enable input.

Top module: `lcd_irq_status`

## Requirements
- R1: After synchronous reset every status flag is 0, the status word reads 0x00000000, and `irq_raw` and `master_hold` are low.
- R2: Layout of the status word: bit 4 is bus error, bit 3 is vertical match, bit 2 is base update and bit 1 is underflow. A read at byte address 0x20 presents the word on `bus_rdata` in the cycle after the `bus_rd` strobe.
- R3: Bits 0 and 31:5 always read 0. Writing ones to those bits changes no flag.
- R4: A write to offset 0x20 clears each flag whose bit in `bus_wdata` is 1. Flags whose bit is 0 keep their value.
- R5: `vphase` is encoded as 0 sync, 1 back porch, 2 active and 3 front porch. The vertical match flag sets when `vphase` becomes equal to `vregion_sel`. It does not set again while the phase stays equal, and it does not set in the other three phases.
- R6: The underflow flag sets on a rising edge of `ev_fifo_upper | ev_fifo_lower`, so either panel alone can set it.
- R7: The base-update flag sets on a rising edge of `ev_base_upper | ev_base_lower`, so either panel alone can set it.
- R8: The bus error flag sets on a rising edge of `ev_bus_err`. `master_hold` equals that flag, so it stays high until software clears bit 4.
- R9: A condition that stays high after its flag has been cleared does not set the flag again. Only a new rising edge does.
- R10: If a set edge and a write-one clear hit the same flag in the same cycle, the flag ends up set. Other flags cleared in that write still clear.
- R11: `irq_raw` is high one cycle after any status flag is set together with its enable bit. Enable bit 0 gates status bit 1, and so on up to enable bit 3, which gates status bit 4.
- R12: A read at any other offset returns 0. A write at any other offset changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data (a one clears a flag) |
| bus_rdata | output | DATA_W | Registered read data |
| ev_bus_err | input | 1 | Error response seen by the bus master |
| ev_base_upper | input | 1 | Upper panel base loaded into its address counter |
| ev_base_lower | input | 1 | Lower panel base loaded into its address counter |
| ev_fifo_upper | input | 1 | Read from the empty upper panel FIFO |
| ev_fifo_lower | input | 1 | Read from the empty lower panel FIFO |
| vphase | input | 2 | Current vertical timing phase |
| vregion_sel | input | 2 | Phase that triggers the vertical match |
| irq_enable | input | 4 | Per-flag interrupt enable |
| master_hold | output | 1 | Keeps the bus master in its error state |
| irq_raw | output | 1 | Registered interrupt request |

## Verification
The bench goes through all sixteen flag patterns against all sixteen enable values. A swapped or unmasked enable bit would raise `irq_raw` for the wrong pattern, or fail to raise it. For each region select, it walks the vertical phases and clears the flag while the phase still matches. A level-sensitive design would set the flag again at once, and one that decodes the select wrongly would fire in the wrong phase. It also holds an underflow condition high across a clear and makes a set collide with a clear. A design that gives the clear priority would lose that event, and one without edge detection would bring the flag straight back. Writes to the reserved bits and to other offsets show whether the address or field decoding is too loose.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;
  localparam int NSRC     = 4;
  localparam int FIELD_LO = 1;
  localparam int SRC_UNDERFLOW = 0;
  localparam int SRC_BASEUPD   = 1;
  localparam int SRC_VMATCH    = 2;
  localparam int SRC_BUSERR    = 3;
  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_BACK   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_FRONT  = 2'd3
  } vphase_e;
endpackage

// File: rtl/lcd_irq_edge.sv
module lcd_irq_edge #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= level[i];
    end
    assign rise[i] = level[i] & ~prev_q[i];
  end
endmodule

// File: rtl/lcd_irq_flags.sv
module lcd_irq_flags #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] stat_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             stat_q[i] <= 1'b0;
      else if (set_vec[i]) stat_q[i] <= 1'b1;
      else if (clr_vec[i]) stat_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_irq_regif.sv
module lcd_irq_regif #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          NSRC     = 4,
  parameter int          FIELD_LO = 1,
  parameter int unsigned OFFSET   = 32'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NSRC-1:0]   stat,
  output logic [NSRC-1:0]   clr_vec,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFSET);

  logic              hit;
  logic [DATA_W-1:0] word;
  logic              unused_wdata;

  assign hit          = (bus_addr == HIT_ADDR);
  assign clr_vec      = (bus_wr && hit) ? bus_wdata[FIELD_LO +: NSRC] : '0;
  assign unused_wdata = ^{bus_wdata[DATA_W-1:FIELD_LO+NSRC], bus_wdata[FIELD_LO-1:0]};

  always_comb begin
    word = '0;
    word[FIELD_LO +: NSRC] = stat;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= hit ? word : '0;
  end
endmodule

// File: rtl/lcd_irq_status.sv
module lcd_irq_status
  import lcd_irq_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int unsigned REG_OFFSET = 32'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_bus_err,
  input  logic              ev_base_upper,
  input  logic              ev_base_lower,
  input  logic              ev_fifo_upper,
  input  logic              ev_fifo_lower,
  input  logic [1:0]        vphase,
  input  logic [1:0]        vregion_sel,
  input  logic [NSRC-1:0]   irq_enable,
  output logic              master_hold,
  output logic              irq_raw
);
  logic [NSRC-1:0] cond_vec;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] stat_q;
  logic            irq_q;

  always_comb begin
    cond_vec                = '0;
    cond_vec[SRC_UNDERFLOW] = ev_fifo_upper | ev_fifo_lower;
    cond_vec[SRC_BASEUPD]   = ev_base_upper | ev_base_lower;
    cond_vec[SRC_VMATCH]    = (vphase_e'(vphase) == vphase_e'(vregion_sel));
    cond_vec[SRC_BUSERR]    = ev_bus_err;
  end

  lcd_irq_edge #(.WIDTH(NSRC)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (cond_vec),
    .rise  (set_vec)
  );

  lcd_irq_flags #(.NSRC(NSRC)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .stat_q  (stat_q)
  );

  lcd_irq_regif #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NSRC     (NSRC),
    .FIELD_LO (FIELD_LO),
    .OFFSET   (REG_OFFSET)
  ) u_regif (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .stat      (stat_q),
    .clr_vec   (clr_vec),
    .bus_rdata (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_q & irq_enable);
  end

  assign irq_raw     = irq_q;
  assign master_hold = stat_q[SRC_BUSERR];
endmodule

// File: rtl/lcd_irq_status_chk.sv
module lcd_irq_status_chk #(
  parameter int DATA_W   = 32,
  parameter int NSRC     = 4,
  parameter int FIELD_LO = 1,
  parameter int ERR_IDX  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ev_bus_err,
  input logic [NSRC-1:0]   irq_enable,
  input logic              master_hold,
  input logic              irq_raw,
  input logic [NSRC-1:0]   set_vec,
  input logic [NSRC-1:0]   clr_vec,
  input logic [NSRC-1:0]   stat_q
);
  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(((1 << NSRC) - 1) << FIELD_LO);

  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~FIELD_MASK) == '0);

  assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec & ~set_vec) != '0) |=> ((stat_q & $past(clr_vec & ~set_vec)) == '0));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (($past(stat_q) & ~$past(clr_vec) & ~stat_q) == '0));

  assert_set_only_on_edge_R9: assert property (@(posedge clk) disable iff (rst)
    ((~$past(stat_q) & stat_q & ~$past(set_vec)) == '0));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  assert_hold_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(master_hold) |-> $past(ev_bus_err));

  assert_hold_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(master_hold) |-> $past(clr_vec[ERR_IDX]));

  assert_irq_high_R11: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & irq_enable) != '0) |=> irq_raw);

  assert_irq_low_R11: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & irq_enable) == '0) |=> !irq_raw);
endmodule

bind lcd_irq_status lcd_irq_status_chk #(
  .DATA_W   (DATA_W),
  .NSRC     (lcd_irq_pkg::NSRC),
  .FIELD_LO (lcd_irq_pkg::FIELD_LO),
  .ERR_IDX  (lcd_irq_pkg::SRC_BUSERR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_rdata   (bus_rdata),
  .ev_bus_err  (ev_bus_err),
  .irq_enable  (irq_enable),
  .master_hold (master_hold),
  .irq_raw     (irq_raw),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec),
  .stat_q      (stat_q)
);

// File: tb/sim_lcd_irq_status.sv
module sim_lcd_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] REG_A = 8'h20;
  localparam logic [7:0] BAD_A = 8'h24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_bus_err = 1'b0;
  logic        ev_base_upper = 1'b0;
  logic        ev_base_lower = 1'b0;
  logic        ev_fifo_upper = 1'b0;
  logic        ev_fifo_lower = 1'b0;
  logic [1:0]  vphase = 2'd0;
  logic [1:0]  vregion_sel = 2'd1;
  logic [3:0]  irq_enable = 4'hF;
  logic        master_hold;
  logic        irq_raw;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_irq_status u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_bus_err(ev_bus_err),
    .ev_base_upper(ev_base_upper), .ev_base_lower(ev_base_lower),
    .ev_fifo_upper(ev_fifo_upper), .ev_fifo_lower(ev_fifo_lower),
    .vphase(vphase), .vregion_sel(vregion_sel), .irq_enable(irq_enable),
    .master_hold(master_hold), .irq_raw(irq_raw)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // m[0] underflow, m[1] base update, m[2] vertical match, m[3] bus error
  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    ev_fifo_upper = m[0]; ev_base_upper = m[1]; ev_bus_err = m[3];
    if (m[2]) vphase = vregion_sel;
    @(negedge clk);
    ev_fifo_upper = 1'b0; ev_base_upper = 1'b0; ev_bus_err = 1'b0;
    vphase = 2'd0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {31'd0, irq_raw}, 32'd0);
    check("R1 hold after reset", {31'd0, master_hold}, 32'd0);
    rd(REG_A, v); check("R1 status after reset", v, 32'd0);

    // R2 / R6 / R7 / R8: each source alone lands on its own bit
    for (int i = 0; i < 4; i++) begin
      pulse(4'(1 << i));
      rd(REG_A, v); check("R2 single source bit", v, 32'(1 << (i + 1)));
      wr(REG_A, 32'h1E);
    end
    // lower panels alone
    @(negedge clk); ev_fifo_lower = 1'b1; @(negedge clk); ev_fifo_lower = 1'b0;
    rd(REG_A, v); check("R6 lower FIFO sets underflow", v, 32'h02);
    @(negedge clk); ev_base_lower = 1'b1; @(negedge clk); ev_base_lower = 1'b0;
    rd(REG_A, v); check("R7 lower base sets update", v, 32'h06);
    wr(REG_A, 32'h1E);

    // R8 hold until cleared
    pulse(4'b1000);
    repeat (5) @(negedge clk);
    check("R8 hold stays high", {31'd0, master_hold}, 32'd1);
    wr(REG_A, 32'h0E);
    check("R8 hold after clearing other bits", {31'd0, master_hold}, 32'd1);
    wr(REG_A, 32'h10);
    check("R8 hold after clearing bit 4", {31'd0, master_hold}, 32'd0);

    // R3 / R4 / R12
    pulse(4'hF);
    wr(REG_A, 32'hFFFF_FFE1);
    rd(REG_A, v); check("R3 reserved write ignored", v, 32'h1E);
    wr(BAD_A, 32'h1E);
    rd(REG_A, v); check("R12 other offset write ignored", v, 32'h1E);
    rd(BAD_A, v); check("R12 other offset reads zero", v, 32'd0);
    wr(REG_A, 32'h0A);
    rd(REG_A, v); check("R4 partial clear", v, 32'h14);
    wr(REG_A, 32'h00);
    rd(REG_A, v); check("R4 zero write keeps", v, 32'h14);
    wr(REG_A, 32'h1E);
    rd(REG_A, v); check("R4 full clear", v, 32'd0);

    // R9: level held high across a clear
    @(negedge clk); ev_fifo_lower = 1'b1;
    repeat (2) @(negedge clk);
    wr(REG_A, 32'h02);
    repeat (3) @(negedge clk);
    rd(REG_A, v); check("R9 held level does not reset flag", v, 32'd0);
    @(negedge clk); ev_fifo_lower = 1'b0;
    @(negedge clk); ev_fifo_upper = 1'b1;
    @(negedge clk); ev_fifo_upper = 1'b0;
    rd(REG_A, v); check("R9 new edge sets flag", v, 32'h02);
    wr(REG_A, 32'h1E);

    // R10: set and clear collide
    pulse(4'b0011);
    @(negedge clk);
    bus_addr = REG_A; bus_wdata = 32'h06; bus_wr = 1'b1; ev_base_lower = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; ev_base_lower = 1'b0;
    rd(REG_A, v); check("R10 set wins over clear", v, 32'h04);
    wr(REG_A, 32'h1E);

    // R5: sweep every region select over every phase
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); vregion_sel = 2'(s); vphase = 2'(s + 1);
      wr(REG_A, 32'h1E);
      for (int k = 1; k < 4; k++) begin
        @(negedge clk); vphase = 2'(s + k);
        rd(REG_A, v); check("R5 no match in other phase", v, 32'd0);
      end
      @(negedge clk); vphase = 2'(s);
      rd(REG_A, v); check("R5 match on phase entry", v, 32'h08);
      wr(REG_A, 32'h08);
      repeat (2) @(negedge clk);
      rd(REG_A, v); check("R5 no re-set while phase holds", v, 32'd0);
      @(negedge clk); vphase = 2'(s + 1);
      rd(REG_A, v); check("R5 leaving phase does not set", v, 32'd0);
    end
    @(negedge clk); vregion_sel = 2'd1; vphase = 2'd0;
    wr(REG_A, 32'h1E);

    // R11: all flag patterns against all enables
    for (int p = 0; p < 16; p++) begin
      wr(REG_A, 32'h1E);
      pulse(4'(p));
      rd(REG_A, v); check("R2 pattern readback", v, 32'(p) << 1);
      check("R8 hold follows pattern", {31'd0, master_hold}, {31'd0, p[3]});
      for (int e = 0; e < 16; e++) begin
        @(negedge clk); irq_enable = 4'(e);
        @(negedge clk);
        check("R11 irq gating", {31'd0, irq_raw}, {31'd0, |(4'(p) & 4'(e))});
      end
    end
    irq_enable = 4'hF;
    wr(REG_A, 32'h1E);
    @(negedge clk);
    check("R11 irq low after clear", {31'd0, irq_raw}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule